// File: doc/BRIEF.md
# IDE DMA transfer sequencer

This block turns one pending drive transfer into a run of storage requests, one per DMA descriptor segment. A start pulse arms it with the drive kind and the transfer geometry. For a disk, that geometry is a sector count, a sector address and a command. For an optical drive, it is a block address and a packet byte count. Each start also pulses a kick toward the descriptor engine. The engine then offers memory segments one at a time. For each accepted segment, the sequencer works out the absolute byte position on the medium and issues one storage request of the segment's length. It then advances its running counters.

A segment offered before the transfer is armed is parked: it moves no data. The transfer ends when a segment arrives and no bytes remain, or when a completion leaves no bytes remaining. The disk then reports ready-and-seek status and raises its interrupt. The optical drive reports command-OK instead. An optical transfer whose block address is all ones is not block based. It is served as a single copy of at most the remaining byte count. Storage errors and illegal disk commands end the transfer with an error status. A flush request is acknowledged only when no storage request is outstanding.

Top module: `ide_dma_seq`

## Requirements
- R1: After reset no storage request is pending, `seg_ready` is high, every pulse output is low, and the transfer is not armed.
- R2: A start accepted while no request is outstanding does four things. It loads the remaining count: `start_pkt_len` for optical, `start_sectors`×512 for disk. It clears the byte index, arms the transfer and pulses `kick` on the next cycle. A start while a request is outstanding is ignored.
- R3: A segment accepted while the transfer is not armed gives a one-cycle `seg_park` pulse on the next cycle, with no request and no status.
- R4: A segment accepted while armed with a remaining count of zero or less finishes the transfer. On the next cycle `xfer_done` and `seg_end` pulse and the transfer disarms. The status is `stat_code`=0 with a `drive_irq` pulse for disk, or `stat_code`=1 with no interrupt for optical.
- R5: A zero-length segment accepted while armed, with bytes remaining, only pulses `seg_end`; the transfer stays armed.
- R6: A block request carries `req_addr`=segment address and `req_len`=segment length. Its offset is LBA×2048+index for optical and sector×512+index for disk. `req_op` is 0 (read) for optical and the disk command otherwise (0 read, 1 write, 2 trim).
- R7: Issuing a block request lowers the remaining count and raises the index by the segment length.
- R8: `req_valid` and its fields stay constant until a `rsp_valid` cycle. `seg_ready` is low meanwhile, so at most one request is outstanding.
- R9: A good completion pulses `seg_end` on the next cycle and drops `req_valid`. If no bytes remain, it also finishes as in R4.
- R10: For optical with LBA all ones, a segment issues one request with `req_op`=3 (copy), offset 0 and length min(remaining, segment length). Its good completion finishes with `stat_code`=1.
- R11: A completion with `rsp_err` pulses `xfer_err` and `seg_end` and disarms. The status is `stat_code`=2 for disk or 3 for optical.
- R12: A disk segment with command 3 issues no request. It pulses `xfer_err` with `stat_code`=2 and `seg_end`, and disarms.
- R13: `flush_ack` pulses once while `flush_req` is high and no request is outstanding; it waits for an outstanding request to complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Start pulse |
| start_optical | input | 1 | 1 optical drive, 0 disk |
| start_cmd | input | 2 | Disk command: 0 read, 1 write, 2 trim |
| start_sectors | input | SECW | Disk sector count |
| start_lba | input | LBAW | Block or sector address |
| start_pkt_len | input | PKTW | Optical packet byte count |
| kick | output | 1 | Pulse to the descriptor engine |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment can be taken |
| seg_addr | input | ADDRW | Segment memory address |
| seg_len | input | LENW | Segment byte length |
| seg_end | output | 1 | Descriptor finished pulse |
| seg_park | output | 1 | Segment parked pulse |
| req_valid | output | 1 | Storage request pending |
| req_op | output | 2 | 0 read, 1 write, 2 trim, 3 copy |
| req_offset | output | OFFW | Storage byte offset |
| req_addr | output | ADDRW | Memory address |
| req_len | output | LENW | Byte length |
| rsp_valid | input | 1 | Storage completion |
| rsp_err | input | 1 | Completion carries an error |
| xfer_done | output | 1 | Transfer finished pulse |
| xfer_err | output | 1 | Transfer failed pulse |
| stat_code | output | 2 | Last status: 0 ready+seek, 1 command OK, 2 DMA error, 3 I/O error |
| drive_irq | output | 1 | Disk interrupt pulse |
| flush_req | input | 1 | Flush request, held until acknowledged |
| flush_ack | output | 1 | Flush acknowledge pulse |

## Verification
The assertions rely on three properties of the inputs. `rsp_valid` is a single-cycle pulse that comes only while a request is pending. `flush_req` stays high until `flush_ack` is seen. A start and a segment offer never fall in the same cycle. The stimulus meets these assumptions in three ways. Its storage responder counts cycles only while `req_valid` is high and answers once. Segment and start drivers run one after the other from a single sequence. The flush driver drops its request on the cycle it sees the acknowledge. A start placed deliberately inside an outstanding request checks that it is ignored.

// File: rtl/ide_seq_pkg.sv
package ide_seq_pkg;

   typedef enum logic [1:0] {
      OP_READ  = 2'd0,
      OP_WRITE = 2'd1,
      OP_TRIM  = 2'd2,
      OP_COPY  = 2'd3
   } op_e;

   typedef enum logic [1:0] {
      STAT_READY_SEEK = 2'd0,
      STAT_CMD_OK     = 2'd1,
      STAT_DMA_ERR    = 2'd2,
      STAT_IO_ERR     = 2'd3
   } stat_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_BUSY = 1'b1
   } st_e;

   typedef enum logic [2:0] {
      D_PARK   = 3'd0,
      D_FINISH = 3'd1,
      D_EMPTY  = 3'd2,
      D_COPY   = 3'd3,
      D_BADCMD = 3'd4,
      D_BLOCK  = 3'd5
   } dec_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ide_seq_cnt.sv
module ide_seq_cnt #(
   parameter int TOTW = 17,
   parameter int LENW = 16,
   parameter int RW   = 19
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [TOTW-1:0]      load_total,
   input  logic                 adv,
   input  logic [LENW-1:0]      adv_len,
   output logic signed [RW-1:0] rem,
   output logic [RW-1:0]        idx,
   output logic                 rem_pos
);

   logic signed [RW-1:0] rem_q;
   logic [RW-1:0]        idx_q;
   logic [RW-1:0]        len_ext;
   logic [RW-1:0]        cons;

   initial begin
      assert (RW > TOTW && RW > LENW)
         else $error("ide_seq_cnt: RW must exceed TOTW and LENW");
   end

   assign len_ext = RW'(adv_len);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q <= '0;
         idx_q <= '0;
      end else if (load) begin
         rem_q <= $signed(RW'(load_total));
         idx_q <= '0;
      end else if (adv) begin
         rem_q <= rem_q - $signed(len_ext);
         idx_q <= idx_q + len_ext;
      end
   end

   assign rem     = rem_q;
   assign idx     = idx_q;
   assign rem_pos = (rem_q != '0) && !rem_q[RW-1];
   assign cons    = $unsigned(rem_q) + idx_q;

   // R7: bytes move from remaining to index, their sum is preserved
   assert_conserve_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load) |=> (cons == $past(cons)));

   // R2: a load clears the index and sets the total
   assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (idx_q == '0 && rem_q == $signed(RW'($past(load_total)))));

endmodule

// File: rtl/ide_seq_off.sv
module ide_seq_off #(
   parameter int LBAW     = 24,
   parameter int RW       = 19,
   parameter int OFFW     = 36,
   parameter int OPT_BLK  = 2048,
   parameter int DISK_BLK = 512
) (
   input  logic            optical,
   input  logic [LBAW-1:0] lba,
   input  logic [RW-1:0]   idx,
   output logic [OFFW-1:0] offset
);

   localparam int OSH = $clog2(OPT_BLK);
   localparam int DSH = $clog2(DISK_BLK);

   logic [OFFW-1:0] lba_w;
   logic [OFFW-1:0] base;

   initial begin
      assert ((1 << OSH) == OPT_BLK) else $error("ide_seq_off: OPT_BLK not a power of two");
      assert ((1 << DSH) == DISK_BLK) else $error("ide_seq_off: DISK_BLK not a power of two");
      assert (OFFW > LBAW + OSH && OFFW > LBAW + DSH && OFFW >= RW)
         else $error("ide_seq_off: OFFW too narrow");
   end

   assign lba_w = OFFW'(lba);

   generate
      if (OSH == DSH) begin : g_one_scale
         logic unused_kind;
         assign unused_kind = optical;
         assign base = lba_w << OSH;
      end else begin : g_two_scale
         assign base = optical ? (lba_w << OSH) : (lba_w << DSH);
      end
   endgenerate

   assign offset = base + OFFW'(idx);

endmodule

// File: rtl/ide_seq_ctrl.sv
module ide_seq_ctrl
   import ide_seq_pkg::*;
#(
   parameter int SECW  = 8,
   parameter int LBAW  = 24,
   parameter int PKTW  = 17,
   parameter int ADDRW = 32,
   parameter int LENW  = 16,
   parameter int TOTW  = 17,
   parameter int RW    = 19,
   parameter int OFFW  = 36,
   parameter int DSH   = 9
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_valid,
   input  logic                 start_optical,
   input  logic [1:0]           start_cmd,
   input  logic [SECW-1:0]      start_sectors,
   input  logic [LBAW-1:0]      start_lba,
   input  logic [PKTW-1:0]      start_pkt_len,
   output logic                 kick,
   input  logic                 seg_valid,
   output logic                 seg_ready,
   input  logic [ADDRW-1:0]     seg_addr,
   input  logic [LENW-1:0]      seg_len,
   output logic                 seg_end,
   output logic                 seg_park,
   output logic                 req_valid,
   output logic [1:0]           req_op,
   output logic [OFFW-1:0]      req_offset,
   output logic [ADDRW-1:0]     req_addr,
   output logic [LENW-1:0]      req_len,
   input  logic                 rsp_valid,
   input  logic                 rsp_err,
   output logic                 xfer_done,
   output logic                 xfer_err,
   output logic [1:0]           stat_code,
   output logic                 drive_irq,
   input  logic                 flush_req,
   output logic                 flush_ack,
   output logic                 cnt_load,
   output logic [TOTW-1:0]      cnt_total,
   output logic                 cnt_adv,
   output logic [LENW-1:0]      cnt_len,
   input  logic signed [RW-1:0] rem,
   input  logic                 rem_pos,
   input  logic [OFFW-1:0]      blk_offset,
   output logic                 opt_sel,
   output logic [LBAW-1:0]      lba_sel
);

   st_e               state_q;
   dec_e              dec;
   op_e               req_op_q;
   stat_e             stat_q;
   logic              active_q, opt_q, copy_q;
   logic [1:0]        cmd_q;
   logic [LBAW-1:0]   lba_q;
   logic              kick_q, seg_end_q, seg_park_q, done_q, err_q, irq_q, fack_q;
   logic              req_valid_q;
   logic [OFFW-1:0]   req_offset_q;
   logic [ADDRW-1:0]  req_addr_q;
   logic [LENW-1:0]   req_len_q;
   logic              start_fire;
   logic              nonblock;
   logic [TOTW-1:0]   sec_w;
   logic [LENW-1:0]   copy_len;

   assign seg_ready  = (state_q == ST_IDLE);
   assign start_fire = start_valid && (state_q == ST_IDLE);
   assign nonblock   = opt_q && (&lba_q);

   // remaining count in bytes on a start
   assign sec_w     = TOTW'(start_sectors);
   assign cnt_total = start_optical ? TOTW'(start_pkt_len) : (sec_w << DSH);
   assign cnt_load  = start_fire;

   // segment classification, in priority order
   always_comb begin
      if (!active_q)                       dec = D_PARK;
      else if (!rem_pos)                   dec = D_FINISH;
      else if (seg_len == '0)              dec = D_EMPTY;
      else if (nonblock)                   dec = D_COPY;
      else if (!opt_q && cmd_q == 2'd3)    dec = D_BADCMD;
      else                                 dec = D_BLOCK;
   end

   assign cnt_adv = seg_valid && seg_ready && (dec == D_BLOCK);
   assign cnt_len = seg_len;

   // rem is positive when a copy is issued
   assign copy_len = ($unsigned(rem) < RW'(seg_len)) ? rem[LENW-1:0] : seg_len;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         active_q     <= 1'b0;
         opt_q        <= 1'b0;
         copy_q       <= 1'b0;
         cmd_q        <= 2'd0;
         lba_q        <= '0;
         kick_q       <= 1'b0;
         seg_end_q    <= 1'b0;
         seg_park_q   <= 1'b0;
         done_q       <= 1'b0;
         err_q        <= 1'b0;
         irq_q        <= 1'b0;
         fack_q       <= 1'b0;
         stat_q       <= STAT_READY_SEEK;
         req_valid_q  <= 1'b0;
         req_op_q     <= OP_READ;
         req_offset_q <= '0;
         req_addr_q   <= '0;
         req_len_q    <= '0;
      end else begin
         kick_q     <= 1'b0;
         seg_end_q  <= 1'b0;
         seg_park_q <= 1'b0;
         done_q     <= 1'b0;
         err_q      <= 1'b0;
         irq_q      <= 1'b0;
         fack_q     <= flush_req && (state_q == ST_IDLE) && !fack_q;

         if (state_q == ST_IDLE) begin
            if (seg_valid) begin
               unique case (dec)
                  D_PARK: seg_park_q <= 1'b1;
                  D_FINISH: begin
                     done_q    <= 1'b1;
                     stat_q    <= opt_q ? STAT_CMD_OK : STAT_READY_SEEK;
                     irq_q     <= !opt_q;
                     active_q  <= 1'b0;
                     seg_end_q <= 1'b1;
                  end
                  D_EMPTY: seg_end_q <= 1'b1;
                  D_BADCMD: begin
                     err_q     <= 1'b1;
                     stat_q    <= STAT_DMA_ERR;
                     active_q  <= 1'b0;
                     seg_end_q <= 1'b1;
                  end
                  D_COPY: begin
                     req_valid_q  <= 1'b1;
                     req_op_q     <= OP_COPY;
                     req_offset_q <= '0;
                     req_addr_q   <= seg_addr;
                     req_len_q    <= copy_len;
                     copy_q       <= 1'b1;
                     state_q      <= ST_BUSY;
                  end
                  default: begin
                     req_valid_q  <= 1'b1;
                     req_op_q     <= opt_q ? OP_READ : op_e'(cmd_q);
                     req_offset_q <= blk_offset;
                     req_addr_q   <= seg_addr;
                     req_len_q    <= seg_len;
                     state_q      <= ST_BUSY;
                  end
               endcase
            end
         end else if (rsp_valid) begin
            req_valid_q <= 1'b0;
            state_q     <= ST_IDLE;
            seg_end_q   <= 1'b1;
            copy_q      <= 1'b0;
            if (rsp_err) begin
               err_q    <= 1'b1;
               stat_q   <= opt_q ? STAT_IO_ERR : STAT_DMA_ERR;
               active_q <= 1'b0;
            end else if (copy_q) begin
               done_q   <= 1'b1;
               stat_q   <= STAT_CMD_OK;
               active_q <= 1'b0;
            end else if (!rem_pos) begin
               done_q   <= 1'b1;
               stat_q   <= opt_q ? STAT_CMD_OK : STAT_READY_SEEK;
               irq_q    <= !opt_q;
               active_q <= 1'b0;
            end
         end

         if (start_fire) begin
            opt_q    <= start_optical;
            cmd_q    <= start_cmd;
            lba_q    <= start_lba;
            active_q <= 1'b1;
            kick_q   <= 1'b1;
         end
      end
   end

   assign kick       = kick_q;
   assign seg_end    = seg_end_q;
   assign seg_park   = seg_park_q;
   assign req_valid  = req_valid_q;
   assign req_op     = req_op_q;
   assign req_offset = req_offset_q;
   assign req_addr   = req_addr_q;
   assign req_len    = req_len_q;
   assign xfer_done  = done_q;
   assign xfer_err   = err_q;
   assign stat_code  = stat_q;
   assign drive_irq  = irq_q;
   assign flush_ack  = fack_q;
   assign opt_sel    = opt_q;
   assign lba_sel    = lba_q;

   // R8: an outstanding request holds its fields until completion
   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_q && !rsp_valid) |=>
         (req_valid_q && $stable(req_offset_q) && $stable(req_len_q) && $stable(req_op_q)));

   // R8: no new segment is taken while a request is outstanding
   assert_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_q |-> !seg_ready);

   // R2: a kick follows a start
   assert_kick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      kick_q |-> $past(start_valid));

   // R3: parking happens only on an unarmed transfer
   assert_park_R3: assert property (@(posedge clk) disable iff (!rst_n)
      seg_park_q |-> !$past(active_q));

   // R4: the interrupt comes only with a disk ready status
   assert_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> (done_q && stat_q == STAT_READY_SEEK));

   // R11: done, error and park never coincide
   assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done_q, err_q, seg_park_q}));

   // R9: a completion closes the descriptor on the next cycle
   assert_close_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_BUSY && rsp_valid) |=> (seg_end_q && !req_valid_q));

   // R13: a flush is acknowledged only with no request outstanding
   assert_flush_R13: assert property (@(posedge clk) disable iff (!rst_n)
      fack_q |-> ($past(state_q == ST_IDLE) && $past(flush_req)));

endmodule

// File: rtl/ide_dma_seq.sv
module ide_dma_seq
   import ide_seq_pkg::*;
#(
   parameter int SECW     = 8,
   parameter int LBAW     = 24,
   parameter int PKTW     = 17,
   parameter int ADDRW    = 32,
   parameter int LENW     = 16,
   parameter int OPT_BLK  = 2048,
   parameter int DISK_BLK = 512,
   parameter int OFFW     = 36
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_valid,
   input  logic             start_optical,
   input  logic [1:0]       start_cmd,
   input  logic [SECW-1:0]  start_sectors,
   input  logic [LBAW-1:0]  start_lba,
   input  logic [PKTW-1:0]  start_pkt_len,
   output logic             kick,
   input  logic             seg_valid,
   output logic             seg_ready,
   input  logic [ADDRW-1:0] seg_addr,
   input  logic [LENW-1:0]  seg_len,
   output logic             seg_end,
   output logic             seg_park,
   output logic             req_valid,
   output logic [1:0]       req_op,
   output logic [OFFW-1:0]  req_offset,
   output logic [ADDRW-1:0] req_addr,
   output logic [LENW-1:0]  req_len,
   input  logic             rsp_valid,
   input  logic             rsp_err,
   output logic             xfer_done,
   output logic             xfer_err,
   output logic [1:0]       stat_code,
   output logic             drive_irq,
   input  logic             flush_req,
   output logic             flush_ack
);

   localparam int DSH  = $clog2(DISK_BLK);
   localparam int TOTW = imax(SECW + DSH, PKTW);
   localparam int RW   = imax(TOTW, LENW) + 2;

   initial begin
      assert (SECW >= 1 && LBAW >= 2 && PKTW >= 1 && LENW >= 1 && ADDRW >= 1)
         else $error("ide_dma_seq: field widths must be positive");
      assert (OFFW >= RW) else $error("ide_dma_seq: OFFW below counter width");
   end

   logic                 cnt_load, cnt_adv, rem_pos, opt_sel;
   logic [TOTW-1:0]      cnt_total;
   logic [LENW-1:0]      cnt_len;
   logic signed [RW-1:0] rem;
   logic [RW-1:0]        idx;
   logic [OFFW-1:0]      blk_offset;
   logic [LBAW-1:0]      lba_sel;

   ide_seq_ctrl #(
      .SECW(SECW), .LBAW(LBAW), .PKTW(PKTW), .ADDRW(ADDRW), .LENW(LENW),
      .TOTW(TOTW), .RW(RW), .OFFW(OFFW), .DSH(DSH)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .start_valid(start_valid), .start_optical(start_optical), .start_cmd(start_cmd),
      .start_sectors(start_sectors), .start_lba(start_lba), .start_pkt_len(start_pkt_len),
      .kick(kick),
      .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr), .seg_len(seg_len),
      .seg_end(seg_end), .seg_park(seg_park),
      .req_valid(req_valid), .req_op(req_op), .req_offset(req_offset),
      .req_addr(req_addr), .req_len(req_len),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err),
      .xfer_done(xfer_done), .xfer_err(xfer_err), .stat_code(stat_code), .drive_irq(drive_irq),
      .flush_req(flush_req), .flush_ack(flush_ack),
      .cnt_load(cnt_load), .cnt_total(cnt_total), .cnt_adv(cnt_adv), .cnt_len(cnt_len),
      .rem(rem), .rem_pos(rem_pos), .blk_offset(blk_offset),
      .opt_sel(opt_sel), .lba_sel(lba_sel)
   );

   ide_seq_cnt #(.TOTW(TOTW), .LENW(LENW), .RW(RW)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .load(cnt_load), .load_total(cnt_total),
      .adv(cnt_adv), .adv_len(cnt_len),
      .rem(rem), .idx(idx), .rem_pos(rem_pos)
   );

   ide_seq_off #(
      .LBAW(LBAW), .RW(RW), .OFFW(OFFW), .OPT_BLK(OPT_BLK), .DISK_BLK(DISK_BLK)
   ) u_off (
      .optical(opt_sel), .lba(lba_sel), .idx(idx), .offset(blk_offset)
   );

endmodule

// File: tb/ide_dma_seq_test.sv
`timescale 1ns/1ps
module ide_dma_seq_test;

   localparam int LBA_ONES = (1 << 24) - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_valid = 1'b0, start_optical = 1'b0;
   logic [1:0]  start_cmd = '0;
   logic [7:0]  start_sectors = '0;
   logic [23:0] start_lba = '0;
   logic [16:0] start_pkt_len = '0;
   logic        kick, seg_ready, seg_end, seg_park;
   logic        seg_valid = 1'b0;
   logic [31:0] seg_addr = '0;
   logic [15:0] seg_len = '0;
   logic        req_valid;
   logic [1:0]  req_op;
   logic [35:0] req_offset;
   logic [31:0] req_addr;
   logic [15:0] req_len;
   logic        rsp_valid = 1'b0, rsp_err = 1'b0;
   logic        xfer_done, xfer_err, drive_irq, flush_ack;
   logic [1:0]  stat_code;
   logic        flush_req = 1'b0;

   int checks = 0;
   int errors = 0;
   int lat = 4;
   bit inject_err = 0;

   always #2 clk = ~clk;

   ide_dma_seq uut (
      .clk(clk), .rst_n(rst_n),
      .start_valid(start_valid), .start_optical(start_optical), .start_cmd(start_cmd),
      .start_sectors(start_sectors), .start_lba(start_lba), .start_pkt_len(start_pkt_len),
      .kick(kick),
      .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr), .seg_len(seg_len),
      .seg_end(seg_end), .seg_park(seg_park),
      .req_valid(req_valid), .req_op(req_op), .req_offset(req_offset),
      .req_addr(req_addr), .req_len(req_len),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err),
      .xfer_done(xfer_done), .xfer_err(xfer_err), .stat_code(stat_code), .drive_irq(drive_irq),
      .flush_req(flush_req), .flush_ack(flush_ack)
   );

   // reference model state and expected outputs
   bit     m_active, m_opt, m_busy, m_copy;
   int     m_cmd, m_lba, m_rem, m_idx;
   bit     e_kick, e_park, e_end, e_done, e_err, e_irq, e_fack, e_rv;
   int     e_code, e_op, e_len;
   longint e_off, e_addr;

   always @(posedge clk) begin
      bit b;
      if (!rst_n) begin
         m_active = 0; m_opt = 0; m_busy = 0; m_copy = 0;
         m_cmd = 0; m_lba = 0; m_rem = 0; m_idx = 0;
         e_kick = 0; e_park = 0; e_end = 0; e_done = 0; e_err = 0; e_irq = 0;
         e_fack = 0; e_rv = 0; e_code = 0; e_op = 0; e_len = 0; e_off = 0; e_addr = 0;
      end else begin
         b = m_busy;
         e_fack = flush_req && !b && !e_fack;
         e_kick = 0; e_park = 0; e_end = 0; e_done = 0; e_err = 0; e_irq = 0;
         if (b) begin
            if (rsp_valid) begin
               m_busy = 0; e_rv = 0; e_end = 1;
               if (rsp_err) begin
                  e_err = 1; e_code = m_opt ? 3 : 2; m_active = 0;
               end else if (m_copy) begin
                  e_done = 1; e_code = 1; m_active = 0;
               end else if (m_rem <= 0) begin
                  e_done = 1; e_code = m_opt ? 1 : 0; e_irq = !m_opt; m_active = 0;
               end
               m_copy = 0;
            end
         end else if (seg_valid) begin
            if (!m_active) e_park = 1;
            else if (m_rem <= 0) begin
               e_done = 1; e_code = m_opt ? 1 : 0; e_irq = !m_opt; m_active = 0; e_end = 1;
            end else if (seg_len == 0) e_end = 1;
            else if (m_opt && m_lba == LBA_ONES) begin
               m_busy = 1; m_copy = 1; e_rv = 1; e_op = 3; e_off = 0; e_addr = seg_addr;
               e_len = (m_rem < int'(seg_len)) ? m_rem : int'(seg_len);
            end else if (!m_opt && m_cmd == 3) begin
               e_err = 1; e_code = 2; m_active = 0; e_end = 1;
            end else begin
               m_busy = 1; e_rv = 1; e_op = m_opt ? 0 : m_cmd;
               e_off = (longint'(m_lba) << (m_opt ? 11 : 9)) + longint'(m_idx);
               e_addr = seg_addr; e_len = seg_len;
               m_rem -= int'(seg_len); m_idx += int'(seg_len);
            end
         end
         if (start_valid && !b) begin
            m_opt = start_optical; m_cmd = start_cmd; m_lba = start_lba;
            m_rem = start_optical ? int'(start_pkt_len) : int'(start_sectors) * 512;
            m_idx = 0; m_active = 1; e_kick = 1;
         end
      end
   end

   task automatic chk(input longint act, input longint exp, input string tag);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk(kick, e_kick, "R2 kick");
         chk(seg_park, e_park, "R3 seg_park");
         chk(xfer_done, e_done, "R4 R9 xfer_done");
         chk(drive_irq, e_irq, "R4 drive_irq");
         chk(stat_code, e_code, "R4 R10 R11 stat_code");
         chk(seg_end, e_end, "R5 R9 seg_end");
         chk(xfer_err, e_err, "R11 R12 xfer_err");
         chk(req_valid, e_rv, "R8 req_valid");
         chk(seg_ready, !m_busy, "R8 seg_ready");
         chk(flush_ack, e_fack, "R13 flush_ack");
         if (e_rv) begin
            chk(req_op, e_op, "R6 R10 req_op");
            chk(req_offset, e_off, "R6 R7 req_offset");
            chk(req_addr, e_addr, "R6 req_addr");
            chk(req_len, e_len, "R6 R10 req_len");
         end
      end
   end

   // storage responder: one answer per request after lat cycles
   initial begin
      int cnt = 0;
      forever begin
         @(negedge clk);
         if (rsp_valid) begin
            rsp_valid = 0; rsp_err = 0; cnt = 0;
         end else if (req_valid) begin
            cnt++;
            if (cnt >= lat) begin
               rsp_valid = 1; rsp_err = inject_err; inject_err = 0;
            end
         end
      end
   end

   task automatic do_start(input bit opt, input int cmd, input int sec, input int lba, input int pkt);
      @(negedge clk);
      start_valid = 1; start_optical = opt; start_cmd = 2'(cmd);
      start_sectors = 8'(sec); start_lba = 24'(lba); start_pkt_len = 17'(pkt);
      @(negedge clk);
      start_valid = 0;
   endtask

   task automatic do_seg(input int addr, input int len);
      @(negedge clk);
      seg_valid = 1; seg_addr = 32'(addr); seg_len = 16'(len);
      @(negedge clk);
      seg_valid = 0;
   endtask

   task automatic settle();
      while (req_valid) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic do_flush();
      @(negedge clk);
      flush_req = 1;
      while (!flush_ack) @(negedge clk);
      flush_req = 0;
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: reset state at the ports
      chk(req_valid, 0, "R1 req_valid after reset");
      chk(seg_ready, 1, "R1 seg_ready after reset");
      chk({kick, seg_end, seg_park, xfer_done, xfer_err, drive_irq, flush_ack}, 0, "R1 pulses after reset");
      // R1/R3: unarmed segment parks
      do_seg('h1000, 16); settle();
      // disk read, two sectors at 5, with an empty segment between (R5, R6, R7, R9, R4)
      do_start(0, 0, 2, 5, 0); settle();
      do_seg('h2000, 512); settle();
      do_seg('h2100, 0); settle();
      do_seg('h2200, 512); settle();
      do_seg('h2300, 64); settle();
      // disk write, overshooting segment (R7, R9)
      do_start(0, 1, 1, 7, 0); settle();
      do_seg('h3000, 300); settle();
      do_seg('h3400, 300); settle();
      // start during outstanding request is ignored (R2)
      do_start(0, 1, 4, 1, 0);
      do_seg('h4000, 512);
      do_start(1, 0, 0, 9, 2048);
      settle();
      do_seg('h4200, 512); settle();
      // disk trim with storage error (R11)
      do_start(0, 2, 3, 'h12345, 0); settle();
      inject_err = 1;
      do_seg('h5000, 512); settle();
      // illegal disk command (R12)
      do_start(0, 3, 1, 2, 0); settle();
      do_seg('h5800, 512); settle();
      // zero sectors finishes at once (R4)
      do_start(0, 0, 0, 4, 0); settle();
      do_seg('h5c00, 128); settle();
      // optical block read (R6, R4)
      do_start(1, 0, 0, 3, 4096); settle();
      do_seg('h6000, 2048); settle();
      do_seg('h6800, 2048); settle();
      do_seg('h7000, 16); settle();
      // optical error (R11)
      do_start(1, 0, 0, 'hABCDE, 4096); settle();
      inject_err = 1;
      do_seg('h7400, 2048); settle();
      // non-block optical copies, capped and uncapped (R10)
      do_start(1, 0, 0, LBA_ONES, 100); settle();
      do_seg('h8000, 256); settle();
      do_start(1, 0, 0, LBA_ONES, 600); settle();
      do_seg('h8400, 256); settle();
      // flush while idle and while a request is outstanding (R13)
      do_flush(); settle();
      do_start(0, 0, 8, 20, 0); settle();
      lat = 12;
      do_seg('h9000, 512);
      do_flush();
      chk(req_valid, 0, "R13 flush_ack after completion");
      settle();
      lat = 4;
      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule